// File: doc/BRIEF.md
# Receive Queue Flow-Control Request Generator

This block watches how full a receive FIFO is and decides when the MAC should tell the far end of the link to stop sending and when to let it start again. Two programmable levels give hysteresis. When the fill level reaches the upper (stop) level, the block asks the transmit path for a flow-control PAUSE frame that carries a programmable pause time. Once the fill level later drops strictly below the lower (resume) level, it asks for a PAUSE frame with a pause time of zero. The transmit side builds that frame: MAC control EtherType 0x8808, sent to the reserved multicast address 01-80-C2-00-00-01. This block only decides when a frame is needed and which pause time it carries.

Both levels are counted in 64-byte units of FIFO occupancy and share one register. A typical setting puts the stop level 5 KB below the FIFO size and the resume level 1 KB below the stop level. If the stop level is set to the full FIFO size or higher, no stop request is ever made. Reset loads that setting, so the block stays silent until software programs it. This is also the right setting for FIFOs of 2 KB or less.

Top module: `rxq_pause_ctl`

## Requirements
- R1: After reset, `req_valid` is 0. Both levels equal the FIFO size in 64-byte units, so no request is made. The pause time register holds 0x1BF0.
- R2: A write with `wr_sel`=0 loads the stop level from `wr_data[TH_W-1:0]` and the resume level from `wr_data[12+TH_W-1:12]`. Both are in 64-byte units, and the new values apply from the next cycle.
- R3: A write with `wr_sel`=1 loads the pause time from `wr_data[15:0]`.
- R4: The block must be in the flowing state, enabled and with no request pending. When `fill_bytes` >= stop level × 64 in that state, `req_valid` rises on the next clock, `req_quanta` equals the pause time, and the block enters the held state.
- R5: Only one stop request is made per crossing. No further stop request comes until a resume request has been made.
- R6: In the held state, enabled and with no request pending, a resume request (`req_quanta`=0) is made when `fill_bytes` < resume level × 64. A fill of exactly resume level × 64 makes no request.
- R7: A request stays high, with `req_quanta` stable, until `req_ack` is sampled high. It is low on the following cycle.
- R8: While the stop level is >= the FIFO size in 64-byte units, no stop request is made. A resume request from the held state is still made.
- R9: While `enable` is 0, no new request is made. The current state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new requests |
| fill_bytes | input | LVL_W | Receive FIFO occupancy in bytes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: level register, 1: pause time register |
| wr_data | input | 12+TH_W | Write data |
| req_ack | input | 1 | Transmit side accepts the pending request |
| req_valid | output | 1 | PAUSE frame request |
| req_quanta | output | 16 | Pause time of the requested frame |

## Verification
The bench builds the block with a 4096-byte FIFO (64 units), 12-bit level fields and no comparator pipeline. With that FIFO, a fill level of exactly the FIFO size equals the disabling stop level, and a stop level one unit lower (63) makes it just reachable. The resume boundary at 1536 bytes can be tested one byte on either side. Both register fields are used at full width, and a request is made in the cycle after the input changes, so the per-clock model needs no latency bookkeeping.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   localparam int QUANTA_W  = 16;
   localparam int XON_LSB   = 12;
   localparam int UNIT_SH   = 6;
   localparam logic [QUANTA_W-1:0] PTIME_RST = 16'h1BF0;

   typedef enum logic {FLOW_ST, HELD_ST} pfg_state_e;
endpackage

// File: rtl/pfg_cfg_regs.sv
module pfg_cfg_regs
   import pfg_pkg::*;
#(
   parameter int TH_W      = 12,
   parameter int RST_UNITS = 320,
   localparam int WD       = XON_LSB + TH_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [WD-1:0]       wr_data,
   output logic [TH_W-1:0]     xoff_units,
   output logic [TH_W-1:0]     xon_units,
   output logic [QUANTA_W-1:0] pause_time
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xoff_units <= TH_W'(RST_UNITS);
         xon_units  <= TH_W'(RST_UNITS);
         pause_time <= PTIME_RST;
      end else if (wr_en) begin
         if (!wr_sel) begin
            xoff_units <= wr_data[TH_W-1:0];
            xon_units  <= wr_data[XON_LSB +: TH_W];
         end else begin
            pause_time <= wr_data[QUANTA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pfg_level_cmp.sv
module pfg_level_cmp
   import pfg_pkg::*;
#(
   parameter int LVL_W      = 15,
   parameter int TH_W       = 12,
   parameter int FIFO_UNITS = 320,
   parameter bit CMP_PIPE   = 1'b0,
   localparam int CW = ((LVL_W > TH_W + UNIT_SH) ? LVL_W : TH_W + UNIT_SH) + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fill_bytes,
   input  logic [TH_W-1:0]  xoff_units,
   input  logic [TH_W-1:0]  xon_units,
   output logic             at_xoff,
   output logic             below_xon,
   output logic             xoff_off
);
   logic [CW-1:0] fill_x, xoff_b, xon_b;
   logic          at_xoff_c, below_xon_c;

   always_comb begin
      fill_x      = CW'(fill_bytes);
      xoff_b      = CW'(xoff_units) << UNIT_SH;
      xon_b       = CW'(xon_units) << UNIT_SH;
      xoff_off    = (xoff_units >= TH_W'(FIFO_UNITS));
      at_xoff_c   = !xoff_off && (fill_x >= xoff_b);
      below_xon_c = (fill_x < xon_b);
   end

   generate
      if (CMP_PIPE) begin : g_pipe
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               at_xoff   <= 1'b0;
               below_xon <= 1'b0;
            end else begin
               at_xoff   <= at_xoff_c;
               below_xon <= below_xon_c;
            end
         end
      end else begin : g_direct
         always_comb begin
            at_xoff   = at_xoff_c;
            below_xon = below_xon_c;
         end
      end
   endgenerate
endmodule

// File: rtl/pfg_req_fsm.sv
module pfg_req_fsm
   import pfg_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                at_xoff,
   input  logic                below_xon,
   input  logic [QUANTA_W-1:0] pause_time,
   input  logic                req_ack,
   output logic                req_valid,
   output logic [QUANTA_W-1:0] req_quanta,
   output logic                held
);
   pfg_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= FLOW_ST;
         req_valid  <= 1'b0;
         req_quanta <= '0;
      end else if (req_valid) begin
         if (req_ack) req_valid <= 1'b0;
      end else if (enable) begin
         case (state_q)
            FLOW_ST: if (at_xoff) begin
               req_valid  <= 1'b1;
               req_quanta <= pause_time;
               state_q    <= HELD_ST;
            end
            HELD_ST: if (below_xon) begin
               req_valid  <= 1'b1;
               req_quanta <= '0;
               state_q    <= FLOW_ST;
            end
            default: state_q <= FLOW_ST;
         endcase
      end
   end

   assign held = (state_q == HELD_ST);
endmodule

// File: rtl/rxq_pause_ctl.sv
module rxq_pause_ctl
   import pfg_pkg::*;
#(
   parameter int FIFO_BYTES = 20480,
   parameter int TH_W       = 12,
   parameter bit CMP_PIPE   = 1'b0,
   localparam int LVL_W      = $clog2(FIFO_BYTES + 1),
   localparam int FIFO_UNITS = FIFO_BYTES >> UNIT_SH,
   localparam int WD         = XON_LSB + TH_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [LVL_W-1:0]    fill_bytes,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [WD-1:0]       wr_data,
   input  logic                req_ack,
   output logic                req_valid,
   output logic [QUANTA_W-1:0] req_quanta
);
   generate
      if (TH_W > XON_LSB || TH_W < 1) begin : g_bad_thw
         $error("TH_W must lie in 1..12");
      end
      if (FIFO_UNITS >= (1 << TH_W)) begin : g_bad_fifo
         $error("FIFO size in 64-byte units must fit in TH_W bits");
      end
      if (WD < QUANTA_W) begin : g_bad_wd
         $error("write data narrower than the pause time field");
      end
   endgenerate

   logic [TH_W-1:0]     xoff_units, xon_units;
   logic [QUANTA_W-1:0] pause_time;
   logic                at_xoff, below_xon, xoff_off, held;

   pfg_cfg_regs #(.TH_W(TH_W), .RST_UNITS(FIFO_UNITS)) u_cfg (
      .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
      .xoff_units, .xon_units, .pause_time
   );

   pfg_level_cmp #(.LVL_W(LVL_W), .TH_W(TH_W), .FIFO_UNITS(FIFO_UNITS),
                   .CMP_PIPE(CMP_PIPE)) u_cmp (
      .clk, .rst_n, .fill_bytes, .xoff_units, .xon_units,
      .at_xoff, .below_xon, .xoff_off
   );

   pfg_req_fsm u_fsm (
      .clk, .rst_n, .enable, .at_xoff, .below_xon, .pause_time,
      .req_ack, .req_valid, .req_quanta, .held
   );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
   import pfg_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                enable,
   input logic                req_ack,
   input logic                req_valid,
   input logic [QUANTA_W-1:0] req_quanta,
   input logic                held,
   input logic                xoff_off,
   input logic [QUANTA_W-1:0] pause_time
);
   p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid);

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_quanta));

   p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid && !enable |=> !req_valid);

   p_xoff_quanta_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && held |-> req_quanta == $past(pause_time));

   p_xon_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && !held |-> req_quanta == '0);

   p_no_xoff_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid && !held && xoff_off |=> !req_valid);

   p_one_per_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> $rose(req_valid));
endmodule

bind rxq_pause_ctl pfg_checker u_pfg_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .req_ack(req_ack),
   .req_valid(req_valid), .req_quanta(req_quanta), .held(held),
   .xoff_off(xoff_off), .pause_time(pause_time)
);

// File: tb/test_rxq_pause_ctl.sv
module test_rxq_pause_ctl;
   localparam int FB  = 4096;
   localparam int TW  = 12;
   localparam int LW  = $clog2(FB + 1);
   localparam int WDW = 12 + TW;
   localparam int FU  = FB / 64;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, req_ack = 1'b0;
   logic [LW-1:0]  fill_bytes = '0;
   logic [WDW-1:0] wr_data = '0;
   logic           req_valid;
   logic [15:0]    req_quanta;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference model state
   int  m_xoff = FU, m_xon = FU, m_pt = 16'h1BF0, m_q = 0;
   bit  m_valid = 1'b0, m_held = 1'b0;

   always #2 clk = ~clk;

   rxq_pause_ctl #(.FIFO_BYTES(FB), .TH_W(TW), .CMP_PIPE(1'b0)) i_rxq_pause_ctl (
      .clk, .rst_n, .enable, .fill_bytes, .wr_en, .wr_sel, .wr_data,
      .req_ack, .req_valid, .req_quanta
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_xoff = FU; m_xon = FU; m_pt = 16'h1BF0; m_q = 0;
         m_valid = 1'b0; m_held = 1'b0;
      end else begin
         if (m_valid) begin
            if (req_ack) m_valid = 1'b0;
         end else if (enable) begin
            if (!m_held && m_xoff < FU && int'(fill_bytes) >= m_xoff * 64) begin
               m_valid = 1'b1; m_q = m_pt; m_held = 1'b1;
            end else if (m_held && int'(fill_bytes) < m_xon * 64) begin
               m_valid = 1'b1; m_q = 0; m_held = 1'b0;
            end
         end
         if (wr_en) begin
            if (!wr_sel) begin
               m_xoff = int'(wr_data[11:0]);
               m_xon  = int'(wr_data[23:12]);
            end else m_pt = int'(wr_data[15:0]);
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (req_valid !== m_valid || (m_valid && int'(req_quanta) != m_q)) begin
            n_bad++;
            $display("FAIL R4/R6/R7 model: valid=%0b quanta=%h expected valid=%0b quanta=%h",
                     req_valid, req_quanta, m_valid, m_q[15:0]);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input bit sel, input int data);
      wr_en = 1'b1; wr_sel = sel; wr_data = WDW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ack();
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
   endtask

   task automatic expect_req(input int q, input string tag);
      chk(req_valid === 1'b1, {tag, " valid"}, int'(req_valid), 1);
      chk(int'(req_quanta) == q, {tag, " quanta"}, int'(req_quanta), q);
   endtask

   task automatic expect_quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(req_valid === 1'b0, tag, int'(req_valid), 0);
      end
   endtask

   initial begin
      cyc(3);
      chk(req_valid === 1'b0, "R1 reset valid", int'(req_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_valid === 1'b0, "R1 after reset", int'(req_valid), 0);
      enable = 1'b1; fill_bytes = LW'(FB);
      expect_quiet(8, "R1 R8 default levels full fifo");

      wr(1'b0, (24 << 12) | 40);            // R2: stop 2560 B, resume 1536 B
      fill_bytes = LW'(2559);
      expect_quiet(3, "R2 R4 one byte under stop");
      fill_bytes = LW'(2560);
      @(negedge clk);
      expect_req(16'h1BF0, "R4 R3 stop at level, default pause time");
      fill_bytes = LW'(1000);
      cyc(5);
      expect_req(16'h1BF0, "R7 held without ack");
      ack();
      chk(req_valid === 1'b0, "R7 drop after ack", int'(req_valid), 0);
      @(negedge clk);
      expect_req(0, "R6 resume after pending cleared");
      ack();

      fill_bytes = LW'(1536);
      expect_quiet(3, "R5 flowing below stop");
      fill_bytes = LW'(3000);
      @(negedge clk);
      expect_req(16'h1BF0, "R4 second stop");
      ack();
      fill_bytes = LW'(4000);
      expect_quiet(10, "R5 no repeat stop");
      fill_bytes = LW'(1536);
      expect_quiet(4, "R6 equal to resume level");
      fill_bytes = LW'(1535);
      @(negedge clk);
      expect_req(0, "R6 strictly below resume");
      ack();

      wr(1'b1, 16'h0123);                   // R3
      enable = 1'b0; fill_bytes = LW'(4000);
      expect_quiet(6, "R9 disabled");
      enable = 1'b1;
      @(negedge clk);
      expect_req(16'h0123, "R3 R9 programmed pause time");
      ack();

      wr(1'b0, (24 << 12) | FU);            // R8: stop level at full size
      fill_bytes = '0;
      @(negedge clk);
      expect_req(0, "R8 resume still made");
      ack();
      fill_bytes = LW'(FB);
      expect_quiet(8, "R8 stop at full size never fires");
      wr(1'b0, (24 << 12) | (FU - 1));
      @(negedge clk);
      expect_req(16'h0123, "R8 R2 stop one unit below full");
      ack();
      cyc(3);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule